// File: doc/BRIEF.md
# Two-Channel DMA Stop and Completion Controller

This block runs dual-address moves for two DMA channels and decides when they stop. Each move is a read of one unit from the source address followed by a write of the same unit to the destination address. The block drives a simple request/acknowledge memory port, and after every completed pair it advances both addresses and lowers the remaining count.

A channel can stop on its own, either when its count runs out or when software drops its enable. Both channels stop together when a shared condition holds: an NMI, an address error, or the master enable going low. A stop never splits a read/write pair. The address and count registers always show the last pair that completed. A completion flag, gated by a per-channel interrupt enable, drives one end interrupt line per channel.

Software loads the registers through plain write strobes. A 16-byte unit setting is legal only with automatic or edge-triggered requests. Any other request mode with 16-byte units is reported as a configuration error.

Top module: `dmat_top`

## Requirements
- R1: After each completed pair, the source and destination addresses each rise by the unit size. The unit code is 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 16 bytes. When the count reaches 0, the channel stops and sets its done flag `te_o`.
- R2: `irq_o[i]` is high exactly while channel i's done flag and its interrupt enable are both set. Clearing the done flag drops the line.
- R3: Writing 0 to a channel's enable stops that channel after the pair in flight. Its done flag stays 0 and its count keeps the value it had.
- R4: A high pulse on `nmi_in` sets `nmif_o`. While `nmif_o` or `ae_o` is 1, no new pair starts on either channel.
- R5: While the master enable `dme_o` is 0, no new pair starts on either channel. Setting it back to 1 lets enabled channels continue.
- R6: After any stop, the address and count registers equal the values produced by the last completed pair. If that pair brought the count to 0, the done flag is set.
- R7: An access whose address is not a multiple of the unit size sets `ae_o`. A source misalignment still lets that pair's write happen, and the pair is counted.
- R8: After the NMI or address-error flag is cleared, a channel with enable 0 stays idle. Setting its enable resumes it from the frozen registers.
- R9: With 16-byte units, each unit lowers the count by 4 and moves each address by 16. In edge mode (request code 1), one rising edge of `dreq[i]` requests exactly one unit.
- R10: `cfg_err_o[i]` is 1 when 16-byte units are combined with level (code 2) or peripheral (code 3) requests, and such a channel never starts. Request code 0 means automatic.
- R11: When both channels are ready, channel 0 wins. Every read is followed in the next bus cycle by that pair's write, with data equal to the data read.
- R12: After reset, all flags, enables, counts and bus requests are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | NCH | Per-channel strobe that loads addresses, count, unit and request mode |
| cfg_sar | input | AW | Source address to load |
| cfg_dar | input | AW | Destination address to load |
| cfg_tcr | input | CW | Transfer count to load |
| cfg_unit | input | 2 | Unit size code |
| cfg_mode | input | 2 | Request mode code |
| ctl_we | input | NCH | Per-channel strobe for the control bits |
| ctl_de | input | 1 | Channel enable value |
| ctl_ie | input | 1 | Interrupt enable value |
| ctl_te_clr | input | 1 | Clears the done flag with the control strobe |
| op_we | input | 1 | Strobe for the shared register |
| op_dme | input | 1 | Master enable value |
| op_nmif_clr | input | 1 | Clears the NMI flag |
| op_ae_clr | input | 1 | Clears the address-error flag |
| nmi_in | input | 1 | NMI event |
| dreq | input | NCH | External request per channel |
| mem_req | output | 1 | Bus cycle request |
| mem_we | output | 1 | 1 = write cycle, 0 = read cycle |
| mem_addr | output | AW | Bus address |
| mem_size | output | 2 | Unit code of the cycle |
| mem_wdata | output | DW | Write data |
| mem_ack | input | 1 | Cycle complete |
| mem_rdata | input | DW | Read data |
| sar_o | output | NCH*AW | Source addresses, channel 0 in the low bits |
| dar_o | output | NCH*AW | Destination addresses |
| tcr_o | output | NCH*CW | Remaining counts |
| de_o | output | NCH | Channel enables |
| te_o | output | NCH | Done flags |
| irq_o | output | NCH | End interrupt requests |
| cfg_err_o | output | NCH | Illegal configuration flags |
| dme_o | output | 1 | Master enable |
| nmif_o | output | 1 | NMI flag |
| ae_o | output | 1 | Address-error flag |

## Verification
The bench builds the block with AW = 16, DW = 16, CW = 8 and NCH = 2. The 16-bit address lets byte, word, longword and 16-byte unit runs be checked against exact end addresses. It also makes odd and unaligned start addresses easy to set up for the address-error path. An 8-bit count keeps the longest runs, such as the halt and resume runs of 40 to 50 pairs, within a few hundred cycles. It also leaves room for counts that are multiples of four for the 16-byte mode. With two channels, the fixed priority can be observed, and halts can be checked to see that they reach both channels.

// File: rtl/dmat_pkg.sv
package dmat_pkg;

    typedef enum logic [1:0] {
        U_BYTE  = 2'd0,
        U_WORD  = 2'd1,
        U_LONG  = 2'd2,
        U_BLK16 = 2'd3
    } unit_e;

    typedef enum logic [1:0] {
        M_AUTO   = 2'd0,
        M_EDGE   = 2'd1,
        M_LEVEL  = 2'd2,
        M_PERIPH = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RD   = 2'd1,
        S_WR   = 2'd2
    } seq_e;

    typedef struct packed {
        unit_e unit;
        mode_e mode;
    } chan_fmt_t;

    function automatic logic [4:0] unit_bytes(unit_e u);
        case (u)
            U_BYTE:  return 5'd1;
            U_WORD:  return 5'd2;
            U_LONG:  return 5'd4;
            default: return 5'd16;
        endcase
    endfunction

    function automatic logic [2:0] unit_step(unit_e u);
        return (u == U_BLK16) ? 3'd4 : 3'd1;
    endfunction

    function automatic logic bad_combo(chan_fmt_t f);
        return (f.unit == U_BLK16) && (f.mode == M_LEVEL || f.mode == M_PERIPH);
    endfunction

    function automatic logic misaligned(logic [3:0] lo, unit_e u);
        logic [4:0] mask;
        mask = unit_bytes(u) - 5'd1;
        return |(lo & mask[3:0]);
    endfunction

endpackage

// File: rtl/dmat_chan.sv
module dmat_chan
    import dmat_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cfg_we,
    input  logic [AW-1:0] cfg_sar,
    input  logic [AW-1:0] cfg_dar,
    input  logic [CW-1:0] cfg_tcr,
    input  chan_fmt_t     cfg_fmt,
    input  logic          ctl_we,
    input  logic          ctl_de,
    input  logic          ctl_ie,
    input  logic          ctl_te_clr,
    input  logic          dreq,
    input  logic          grant,
    input  logic          done,
    output logic [AW-1:0] sar,
    output logic [AW-1:0] dar,
    output logic [CW-1:0] tcr,
    output unit_e         unit,
    output logic          de,
    output logic          te,
    output logic          irq,
    output logic          cfg_err,
    output logic          want
);

    chan_fmt_t     fmt_q;
    logic          ie_q;
    logic          dreq_q;
    logic          pend_q;
    logic          req_ok;
    logic [CW-1:0] step;
    logic [CW-1:0] tcr_nx;
    logic [AW-1:0] adv;

    always_comb begin
        step   = CW'(unit_step(fmt_q.unit));
        tcr_nx = (tcr > step) ? tcr - step : '0;
        adv    = AW'(unit_bytes(fmt_q.unit));
        case (fmt_q.mode)
            M_AUTO:  req_ok = 1'b1;
            M_EDGE:  req_ok = pend_q;
            default: req_ok = dreq;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sar    <= '0;
            dar    <= '0;
            tcr    <= '0;
            fmt_q  <= '0;
            de     <= 1'b0;
            ie_q   <= 1'b0;
            te     <= 1'b0;
            dreq_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            dreq_q <= dreq;
            if (grant)
                pend_q <= 1'b0;
            else if (fmt_q.mode == M_EDGE && dreq && !dreq_q)
                pend_q <= 1'b1;
            if (cfg_we) begin
                sar   <= cfg_sar;
                dar   <= cfg_dar;
                tcr   <= cfg_tcr;
                fmt_q <= cfg_fmt;
            end else if (done) begin
                sar <= sar + adv;
                dar <= dar + adv;
                tcr <= tcr_nx;
                if (tcr_nx == '0)
                    te <= 1'b1;
            end
            if (ctl_we) begin
                de   <= ctl_de;
                ie_q <= ctl_ie;
                if (ctl_te_clr)
                    te <= 1'b0;
            end
        end
    end

    assign unit    = fmt_q.unit;
    assign cfg_err = bad_combo(fmt_q);
    assign irq     = te & ie_q;
    assign want    = de & ~te & (tcr != '0) & ~cfg_err & req_ok;

endmodule

// File: rtl/dmat_seq.sv
module dmat_seq
    import dmat_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int NCH = 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [NCH-1:0] want,
    input  logic           halt,
    input  logic [AW-1:0]  sar [NCH],
    input  logic [AW-1:0]  dar [NCH],
    input  unit_e          unit [NCH],
    input  logic           mem_ack,
    input  logic [DW-1:0]  mem_rdata,
    output logic           mem_req,
    output logic           mem_we,
    output logic [AW-1:0]  mem_addr,
    output logic [1:0]     mem_size,
    output logic [DW-1:0]  mem_wdata,
    output logic [NCH-1:0] grant,
    output logic [NCH-1:0] done,
    output logic           ae_set
);

    localparam int IW = (NCH > 1) ? $clog2(NCH) : 1;

    seq_e          st_q;
    logic [IW-1:0] ch_q;
    logic [IW-1:0] pick;
    logic          found;
    logic          start;
    logic [DW-1:0] buf_q;

    always_comb begin
        pick  = '0;
        found = 1'b0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (want[i]) begin
                pick  = IW'(i);
                found = 1'b1;
            end
        end
        start = (st_q == S_IDLE) && !halt && found;
        grant = '0;
        if (start)
            grant[pick] = 1'b1;
        done = '0;
        if (st_q == S_WR && mem_ack)
            done[ch_q] = 1'b1;
    end

    assign mem_req   = (st_q != S_IDLE);
    assign mem_we    = (st_q == S_WR);
    assign mem_addr  = mem_we ? dar[ch_q] : sar[ch_q];
    assign mem_size  = unit[ch_q];
    assign mem_wdata = buf_q;
    assign ae_set    = mem_req && misaligned(mem_addr[3:0], unit[ch_q]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= S_IDLE;
            ch_q  <= '0;
            buf_q <= '0;
        end else begin
            case (st_q)
                S_IDLE: if (start) begin
                    ch_q <= pick;
                    st_q <= S_RD;
                end
                S_RD: if (mem_ack) begin
                    buf_q <= mem_rdata;
                    st_q  <= S_WR;
                end
                S_WR: if (mem_ack)
                    st_q <= S_IDLE;
                default: st_q <= S_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/dmat_top.sv
module dmat_top
    import dmat_pkg::*;
#(
    parameter int AW  = 16,
    parameter int DW  = 16,
    parameter int CW  = 8,
    parameter int NCH = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    cfg_we,
    input  logic [AW-1:0]     cfg_sar,
    input  logic [AW-1:0]     cfg_dar,
    input  logic [CW-1:0]     cfg_tcr,
    input  logic [1:0]        cfg_unit,
    input  logic [1:0]        cfg_mode,
    input  logic [NCH-1:0]    ctl_we,
    input  logic              ctl_de,
    input  logic              ctl_ie,
    input  logic              ctl_te_clr,
    input  logic              op_we,
    input  logic              op_dme,
    input  logic              op_nmif_clr,
    input  logic              op_ae_clr,
    input  logic              nmi_in,
    input  logic [NCH-1:0]    dreq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [1:0]        mem_size,
    output logic [DW-1:0]     mem_wdata,
    input  logic              mem_ack,
    input  logic [DW-1:0]     mem_rdata,
    output logic [NCH*AW-1:0] sar_o,
    output logic [NCH*AW-1:0] dar_o,
    output logic [NCH*CW-1:0] tcr_o,
    output logic [NCH-1:0]    de_o,
    output logic [NCH-1:0]    te_o,
    output logic [NCH-1:0]    irq_o,
    output logic [NCH-1:0]    cfg_err_o,
    output logic              dme_o,
    output logic              nmif_o,
    output logic              ae_o
);

    logic [AW-1:0]  sar_w [NCH];
    logic [AW-1:0]  dar_w [NCH];
    unit_e          unit_w [NCH];
    logic [NCH-1:0] want;
    logic [NCH-1:0] grant;
    logic [NCH-1:0] done;
    logic           ae_set;
    logic           halt;
    chan_fmt_t      fmt_in;

    assign fmt_in = '{unit: unit_e'(cfg_unit), mode: mode_e'(cfg_mode)};
    assign halt   = ~dme_o | nmif_o | ae_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            dme_o  <= 1'b0;
            nmif_o <= 1'b0;
            ae_o   <= 1'b0;
        end else begin
            if (op_we)
                dme_o <= op_dme;
            if (nmi_in)
                nmif_o <= 1'b1;
            else if (op_we && op_nmif_clr)
                nmif_o <= 1'b0;
            if (ae_set)
                ae_o <= 1'b1;
            else if (op_we && op_ae_clr)
                ae_o <= 1'b0;
        end
    end

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        dmat_chan #(.AW(AW), .CW(CW)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .cfg_we     (cfg_we[g]),
            .cfg_sar    (cfg_sar),
            .cfg_dar    (cfg_dar),
            .cfg_tcr    (cfg_tcr),
            .cfg_fmt    (fmt_in),
            .ctl_we     (ctl_we[g]),
            .ctl_de     (ctl_de),
            .ctl_ie     (ctl_ie),
            .ctl_te_clr (ctl_te_clr),
            .dreq       (dreq[g]),
            .grant      (grant[g]),
            .done       (done[g]),
            .sar        (sar_w[g]),
            .dar        (dar_w[g]),
            .tcr        (tcr_o[g*CW +: CW]),
            .unit       (unit_w[g]),
            .de         (de_o[g]),
            .te         (te_o[g]),
            .irq        (irq_o[g]),
            .cfg_err    (cfg_err_o[g]),
            .want       (want[g])
        );
        assign sar_o[g*AW +: AW] = sar_w[g];
        assign dar_o[g*AW +: AW] = dar_w[g];
    end

    dmat_seq #(.AW(AW), .DW(DW), .NCH(NCH)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .want      (want),
        .halt      (halt),
        .sar       (sar_w),
        .dar       (dar_w),
        .unit      (unit_w),
        .mem_ack   (mem_ack),
        .mem_rdata (mem_rdata),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_size  (mem_size),
        .mem_wdata (mem_wdata),
        .grant     (grant),
        .done      (done),
        .ae_set    (ae_set)
    );

endmodule

// File: rtl/dmat_chk.sv
module dmat_chk #(
    parameter int AW  = 16,
    parameter int CW  = 8,
    parameter int NCH = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ack,
    input logic [NCH-1:0]    cfg_we,
    input logic [NCH*AW-1:0] sar_o,
    input logic [NCH*AW-1:0] dar_o,
    input logic [NCH*CW-1:0] tcr_o,
    input logic [NCH-1:0]    te_o,
    input logic              dme_o,
    input logic              nmif_o,
    input logic              ae_o
);

    logic halted;
    assign halted = nmif_o | ae_o | ~dme_o;

    // R11, R7: a finished read is always followed by the pair's write
    a_r11_write_follows_read: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_we && mem_ack) |=> (mem_req && mem_we));

    // R4, R5: no new pair begins while a shared stop condition holds
    a_r4_halt_blocks_start: assert property (@(posedge clk) disable iff (rst)
        (!mem_req && halted) |=> !mem_req);

    // R6: halted registers stay frozen unless software reloads them
    a_r6_regs_frozen: assert property (@(posedge clk) disable iff (rst)
        (!mem_req && halted && cfg_we == '0) |=>
            ($stable(sar_o) && $stable(dar_o) && $stable(tcr_o)));

    for (genvar g = 0; g < NCH; g++) begin : g_te
        // R1: the done flag rises only together with a zero count
        a_r1_te_at_zero: assert property (@(posedge clk) disable iff (rst)
            $rose(te_o[g]) |-> (tcr_o[g*CW +: CW] == '0));
    end

endmodule

bind dmat_top dmat_chk #(.AW(AW), .CW(CW), .NCH(NCH)) u_chk (
    .clk     (clk),
    .rst     (rst),
    .mem_req (mem_req),
    .mem_we  (mem_we),
    .mem_ack (mem_ack),
    .cfg_we  (cfg_we),
    .sar_o   (sar_o),
    .dar_o   (dar_o),
    .tcr_o   (tcr_o),
    .te_o    (te_o),
    .dme_o   (dme_o),
    .nmif_o  (nmif_o),
    .ae_o    (ae_o)
);

// File: tb/tb_dmat_top.sv
module tb_dmat_top;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;
    localparam int DW = 16;
    localparam int CW = 8;
    localparam int NCH = 2;

    // {ch, unit, count, src, dst, expected final src}
    localparam logic [63:0] VEC [5] = '{
        {4'd0, 4'd0, 8'd3, 16'h0100, 16'h0200, 16'h0103},
        {4'd1, 4'd1, 8'd4, 16'h0300, 16'h0400, 16'h0308},
        {4'd0, 4'd2, 8'd2, 16'h1000, 16'h2000, 16'h1008},
        {4'd1, 4'd3, 8'd8, 16'h4000, 16'h5000, 16'h4020},
        {4'd0, 4'd0, 8'd1, 16'h00FF, 16'h01FF, 16'h0100}
    };

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NCH-1:0]    cfg_we = '0;
    logic [AW-1:0]     cfg_sar = '0;
    logic [AW-1:0]     cfg_dar = '0;
    logic [CW-1:0]     cfg_tcr = '0;
    logic [1:0]        cfg_unit = '0;
    logic [1:0]        cfg_mode = '0;
    logic [NCH-1:0]    ctl_we = '0;
    logic              ctl_de = 1'b0;
    logic              ctl_ie = 1'b0;
    logic              ctl_te_clr = 1'b0;
    logic              op_we = 1'b0;
    logic              op_dme = 1'b0;
    logic              op_nmif_clr = 1'b0;
    logic              op_ae_clr = 1'b0;
    logic              nmi_in = 1'b0;
    logic [NCH-1:0]    dreq = '0;
    logic              mem_req, mem_we, mem_ack;
    logic [AW-1:0]     mem_addr;
    logic [1:0]        mem_size;
    logic [DW-1:0]     mem_wdata, mem_rdata;
    logic [NCH*AW-1:0] sar_o, dar_o;
    logic [NCH*CW-1:0] tcr_o;
    logic [NCH-1:0]    de_o, te_o, irq_o, cfg_err_o;
    logic              dme_o, nmif_o, ae_o;

    int n_chk = 0;
    int n_bad = 0;
    int wr_cnt = 0;
    logic [AW-1:0] last_rd = '0;
    bit done_run = 1'b0;

    dmat_top #(.AW(AW), .DW(DW), .CW(CW), .NCH(NCH)) dut (.*);

    assign mem_ack   = mem_req;
    assign mem_rdata = mem_addr ^ 16'h5A5A;

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // R11: every write carries the data of the read just before it
    always @(negedge clk) begin
        if (!rst && mem_req) begin
            if (!mem_we) last_rd = mem_addr;
            else begin
                wr_cnt++;
                check("R11 write data", 32'(mem_wdata), 32'(last_rd ^ 16'h5A5A));
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done_run) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=finished");
            summary();
        end
    end

    function automatic logic [AW-1:0] sar_of(int c); return sar_o[c*AW +: AW]; endfunction
    function automatic logic [AW-1:0] dar_of(int c); return dar_o[c*AW +: AW]; endfunction
    function automatic logic [CW-1:0] tcr_of(int c); return tcr_o[c*CW +: CW]; endfunction

    task automatic idle(int n); repeat (n) @(negedge clk); endtask

    task automatic do_cfg(int c, logic [15:0] s, logic [15:0] d, logic [7:0] t,
                          logic [1:0] u, logic [1:0] m);
        @(negedge clk);
        cfg_we = '0; cfg_we[c] = 1'b1;
        cfg_sar = s; cfg_dar = d; cfg_tcr = t; cfg_unit = u; cfg_mode = m;
        @(negedge clk);
        cfg_we = '0;
    endtask

    task automatic do_ctl(int c, logic de, logic ie, logic tc);
        @(negedge clk);
        ctl_we = '0; ctl_we[c] = 1'b1;
        ctl_de = de; ctl_ie = ie; ctl_te_clr = tc;
        @(negedge clk);
        ctl_we = '0; ctl_te_clr = 1'b0;
    endtask

    task automatic do_op(logic dme, logic nclr, logic aclr);
        @(negedge clk);
        op_we = 1'b1; op_dme = dme; op_nmif_clr = nclr; op_ae_clr = aclr;
        @(negedge clk);
        op_we = 1'b0; op_nmif_clr = 1'b0; op_ae_clr = 1'b0;
    endtask

    initial begin
        logic [CW-1:0] t1;
        int w0;
        idle(3);
        rst = 1'b0;
        idle(1);
        // R12: reset state
        check("R12 mem_req", 32'(mem_req), 0);
        check("R12 flags", {te_o, irq_o, de_o, nmif_o, ae_o, dme_o}, 0);
        check("R12 count", 32'(tcr_o), 0);

        do_op(1'b1, 1'b0, 1'b0);

        // table of runs to completion: R1, R2, R9
        for (int v = 0; v < 5; v++) begin
            int c, units;
            logic [3:0] u;
            logic [7:0] t;
            logic [15:0] s, d, es;
            c  = int'(VEC[v][63:60]);
            u  = VEC[v][59:56];
            t  = VEC[v][55:48];
            s  = VEC[v][47:32];
            d  = VEC[v][31:16];
            es = VEC[v][15:0];
            units = (u == 4'd3) ? int'(t) / 4 : int'(t);
            w0 = wr_cnt;
            do_cfg(c, s, d, t, u[1:0], 2'd0);
            do_ctl(c, 1'b1, 1'b1, 1'b0);
            idle(3 * int'(t) + 6);
            check("R1 final src", 32'(sar_of(c)), 32'(es));
            check("R1 final dst", 32'(dar_of(c)), 32'(d + (es - s)));
            check("R1 count zero", 32'(tcr_of(c)), 0);
            check("R1 done flag", 32'(te_o[c]), 1);
            check("R9 pair count", 32'(wr_cnt - w0), 32'(units));
            check("R2 irq raised", 32'(irq_o[c]), 1);
            do_ctl(c, 1'b0, 1'b1, 1'b1);
            check("R2 irq dropped", 32'(irq_o[c]), 0);
        end

        // R3: dropping one channel's enable
        do_cfg(0, 16'h0800, 16'h0900, 8'd50, 2'd0, 2'd0);
        do_ctl(0, 1'b1, 1'b0, 1'b0);
        idle(10);
        do_ctl(0, 1'b0, 1'b0, 1'b0);
        idle(4);
        t1 = tcr_of(0);
        check("R3 bus quiet", 32'(mem_req), 0);
        check("R3 partial count", 32'(t1 > 0 && t1 < 50), 1);
        idle(8);
        check("R3 count held", 32'(tcr_of(0)), 32'(t1));
        check("R3 no done flag", 32'(te_o[0]), 0);
        check("R1 src matches count", 32'(sar_of(0) - 16'h0800), 32'(50 - t1));

        // R4, R6, R8: NMI halt and restart
        do_cfg(0, 16'h0A00, 16'h0B00, 8'd40, 2'd0, 2'd0);
        do_ctl(0, 1'b1, 1'b0, 1'b0);
        idle(9);
        nmi_in = 1'b1;
        idle(1);
        nmi_in = 1'b0;
        idle(4);
        check("R4 nmi flag", 32'(nmif_o), 1);
        check("R4 bus quiet", 32'(mem_req), 0);
        t1 = tcr_of(0);
        idle(6);
        check("R4 count held", 32'(tcr_of(0)), 32'(t1));
        check("R6 src frozen", 32'(sar_of(0) - 16'h0A00), 32'(40 - t1));
        check("R6 dst frozen", 32'(dar_of(0) - 16'h0B00), 32'(40 - t1));
        do_ctl(0, 1'b0, 1'b0, 1'b0);
        do_op(1'b1, 1'b1, 1'b0);
        idle(8);
        check("R8 flag cleared", 32'(nmif_o), 0);
        check("R8 disabled stays idle", 32'(tcr_of(0)), 32'(t1));
        do_ctl(0, 1'b1, 1'b0, 1'b0);
        idle(3 * int'(t1) + 6);
        check("R8 resumed to end", 32'(tcr_of(0)), 0);
        check("R8 end src", 32'(sar_of(0)), 32'h0A28);
        check("R8 done flag", 32'(te_o[0]), 1);
        do_ctl(0, 1'b0, 1'b0, 1'b1);

        // R7: misaligned source, write still completes
        do_cfg(0, 16'h0101, 16'h0600, 8'd5, 2'd1, 2'd0);
        w0 = wr_cnt;
        do_ctl(0, 1'b1, 1'b0, 1'b0);
        idle(8);
        check("R7 ae flag", 32'(ae_o), 1);
        check("R7 one write", 32'(wr_cnt - w0), 1);
        check("R7 count", 32'(tcr_of(0)), 4);
        check("R6 src after ae", 32'(sar_of(0)), 32'h0103);
        check("R6 dst after ae", 32'(dar_of(0)), 32'h0602);
        do_ctl(0, 1'b0, 1'b0, 1'b0);
        do_op(1'b1, 1'b0, 1'b1);
        check("R7 ae cleared", 32'(ae_o), 0);
        // R6: the halted pair was the last one
        do_cfg(0, 16'h0203, 16'h0700, 8'd1, 2'd1, 2'd0);
        do_ctl(0, 1'b1, 1'b0, 1'b0);
        idle(6);
        check("R6 ae on final", 32'(ae_o), 1);
        check("R6 done on final", 32'(te_o[0]), 1);
        do_op(1'b1, 1'b0, 1'b1);
        do_ctl(0, 1'b0, 1'b0, 1'b1);

        // R5: master enable
        do_cfg(1, 16'h1100, 16'h1200, 8'd40, 2'd0, 2'd0);
        do_ctl(1, 1'b1, 1'b0, 1'b0);
        idle(9);
        do_op(1'b0, 1'b0, 1'b0);
        idle(4);
        check("R5 bus quiet", 32'(mem_req), 0);
        t1 = tcr_of(1);
        idle(6);
        check("R5 count held", 32'(tcr_of(1)), 32'(t1));
        check("R6 src on dme stop", 32'(sar_of(1) - 16'h1100), 32'(40 - t1));
        do_op(1'b1, 1'b0, 1'b0);
        idle(9);
        check("R5 resumes", 32'(tcr_of(1) < t1), 1);
        do_ctl(1, 1'b0, 1'b0, 1'b0);
        idle(4);

        // R11: channel 0 first
        do_op(1'b0, 1'b0, 1'b0);
        do_cfg(0, 16'h2000, 16'h2100, 8'd6, 2'd0, 2'd0);
        do_cfg(1, 16'h3000, 16'h3100, 8'd6, 2'd0, 2'd0);
        do_ctl(0, 1'b1, 1'b0, 1'b0);
        do_ctl(1, 1'b1, 1'b0, 1'b0);
        do_op(1'b1, 1'b0, 1'b0);
        idle(9);
        check("R11 ch1 waits", 32'(tcr_of(1)), 6);
        check("R11 ch0 runs", 32'(tcr_of(0) < 6), 1);
        idle(40);
        check("R11 both done", 32'(te_o), 32'h3);
        do_ctl(0, 1'b0, 1'b0, 1'b1);
        do_ctl(1, 1'b1, 1'b0, 1'b1);

        // R10: illegal 16-byte combination
        do_cfg(1, 16'h4000, 16'h4100, 8'd8, 2'd3, 2'd2);
        dreq[1] = 1'b1;
        idle(8);
        check("R10 cfg error", 32'(cfg_err_o[1]), 1);
        check("R10 never starts", 32'(tcr_of(1)), 8);
        dreq[1] = 1'b0;
        // R9: edge-requested 16-byte units
        do_cfg(1, 16'h4000, 16'h4100, 8'd8, 2'd3, 2'd1);
        check("R10 legal edge mode", 32'(cfg_err_o[1]), 0);
        idle(4);
        check("R9 waits for edge", 32'(tcr_of(1)), 8);
        dreq[1] = 1'b1;
        idle(1);
        dreq[1] = 1'b0;
        idle(6);
        check("R9 count minus four", 32'(tcr_of(1)), 4);
        check("R9 src plus sixteen", 32'(sar_of(1)), 32'h4010);
        idle(6);
        check("R9 one unit per edge", 32'(tcr_of(1)), 4);
        dreq[1] = 1'b1;
        idle(1);
        dreq[1] = 1'b0;
        idle(6);
        check("R9 final unit", 32'(tcr_of(1)), 0);
        check("R9 done flag", 32'(te_o[1]), 1);

        done_run = 1'b1;
        summary();
    end

endmodule